// File: doc/BRIEF.md
# BAR Aperture and Type Encoder

This block turns one base-address-register request into the fields a PCIe endpoint's BAR setup registers expect. A request carries a byte size, a base address, a BAR index and three attribute flags: I/O space, prefetchable and 64-bit type. From these the block produces four things. The first is a size-class code that counts power-of-two steps above a 128-byte minimum. The second is a 3-bit control code for the address-space type. The third is the word and field slot the BAR occupies inside a shared setup word. The fourth is the base address split into two 32-bit halves.

It also reports whether the BAR had to be promoted to 64-bit, which is returned as an updated 64-bit type flag. It flags requests the hardware cannot hold. A separate disable request produces the field values that switch a BAR off.

Requests use a valid/ready handshake on the input side. One registered result appears per accepted request, in the cycle after acceptance. The output carries no back-pressure.

Top module: `bar_cfg_encoder`

## Requirements
- R1: Any requested size below 128 bytes, including zero, is handled exactly as a 128-byte request and yields size code 0.
- R2: The effective size is the smallest power of two at or above the (floored) request, computed over all 64 bits; `out_aperture` equals log2(effective size) minus 7, so 129 bytes gives 1 and 512 bytes gives 2.
- R3: When log2(effective size) minus 7 exceeds 31, the request is rejected with `out_err`=1. This happens for any effective size above 2^38 bytes, including requests above 2^63.
- R4: An I/O request (`in_is_io`=1) gets control code 1 whatever its size or BAR index, and its 64-bit flag is returned unchanged.
- R5: A memory BAR counts as 64-bit only when its effective size exceeds 2^31 bytes. Control code 4 means 32-bit, 5 means 32-bit prefetchable, 6 means 64-bit and 7 means 64-bit prefetchable.
- R6: A 64-bit memory BAR requested at an odd BAR index is rejected with `out_err`=1.
- R7: For an accepted 64-bit memory BAR, `out_mem64` is 1 even when `in_mem64` was 0; otherwise `out_mem64` equals `in_mem64`.
- R8: `out_word` is 1 when the BAR index is 4 or more, otherwise 0. `out_slot` is the index modulo 4, so indices 0..3 land in slots 0..3 of word 0 and indices 4 and 5 land in slots 0 and 1 of word 1.
- R9: For an accepted non-disable request, `out_addr_lo` is bits 31:0 of `in_base` and `out_addr_hi` is bits 63:32.
- R10: A disable request (`in_disable`=1) at index 0..5 yields control code 0, size code 0, both address words 0, no error, and `out_mem64` equal to `in_mem64`, regardless of size and flags.
- R11: Both `in_ready` and `out_valid` are 0 in reset. `in_ready` is 1 from the first clock after reset. `out_valid` is 1 exactly in the cycle after a request is accepted, and all result fields are valid in that cycle.
- R12: A BAR index of 6 or 7 is rejected with `out_err`=1. Any rejected request yields control code 0, size code 0, both address words 0 and `out_mem64` equal to `in_mem64`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block accepts a request this cycle |
| in_size | input | 64 | Requested BAR size in bytes |
| in_is_io | input | 1 | Request is for I/O space |
| in_prefetch | input | 1 | Memory BAR is prefetchable |
| in_mem64 | input | 1 | Caller already asks for 64-bit type |
| in_disable | input | 1 | Produce disable values instead of a setup |
| in_bar | input | 3 | BAR index |
| in_base | input | 64 | Base address |
| out_valid | output | 1 | Result present |
| out_aperture | output | 5 | Size code |
| out_ctrl | output | 3 | Address-space control code |
| out_word | output | 1 | Which shared setup word holds the fields |
| out_slot | output | 2 | Field slot inside that word |
| out_mem64 | output | 1 | Updated 64-bit type flag |
| out_err | output | 1 | Request rejected |
| out_addr_lo | output | 32 | Base address bits 31:0 |
| out_addr_hi | output | 32 | Base address bits 63:32 |

## Verification
Some rules are checked by assertions on every cycle:
- A rejected result always carries zeroed codes.
- A 64-bit control code never lands in an odd slot and always comes with the 64-bit flag set.
- A result never appears without an accepted request one cycle earlier.

The arithmetic cannot be checked that way, and only the bench's scenarios, compared against a behavioural model, can show it:
- the 128-byte floor;
- rounding at and just past each power of two;
- the 2 GiB promotion boundary;
- the code-width limit near 2^38 and above 2^63;
- the I/O exemption from the odd-index rule;
- the disable path and the mapping of indices 4 to 7.

// File: rtl/bar_enc_pkg.sv
package bar_enc_pkg;
    // Control codes decoded by the BAR setup logic downstream
    typedef enum logic [2:0] {
        CTRL_OFF    = 3'd0,
        CTRL_IO32   = 3'd1,
        CTRL_MEM32  = 3'd4,
        CTRL_PMEM32 = 3'd5,
        CTRL_MEM64  = 3'd6,
        CTRL_PMEM64 = 3'd7
    } bar_ctrl_e;

    localparam int CTRL_W = 3;
endpackage

// File: rtl/bar_size_class.sv
module bar_size_class #(
    parameter int SIZE_W    = 64,
    parameter int APER_W    = 5,
    parameter int MIN_LOG2  = 7,
    parameter int WIDE_LOG2 = 31
) (
    input  logic [SIZE_W-1:0] req_size,
    output logic [APER_W-1:0] aperture,
    output logic              wide,
    output logic              too_big
);
    localparam int LOG_W = $clog2(SIZE_W + 1);
    localparam logic [SIZE_W-1:0] FLOOR_SZ = SIZE_W'(1) << MIN_LOG2;
    localparam logic [LOG_W-1:0] APER_MAX = LOG_W'((1 << APER_W) - 1);

    logic [SIZE_W-1:0] floored;
    logic [SIZE_W-1:0] minus_one;
    logic [LOG_W-1:0]  lg;
    logic [LOG_W-1:0]  ap_full;

    always_comb begin
        floored   = (req_size < FLOOR_SZ) ? FLOOR_SZ : req_size;
        minus_one = floored - SIZE_W'(1);
        lg        = '0;
        // position of highest set bit plus one gives the rounded-up log2
        for (int i = 0; i < SIZE_W; i++) begin
            if (minus_one[i]) lg = LOG_W'(i + 1);
        end
        ap_full  = lg - LOG_W'(MIN_LOG2);
        too_big  = ap_full > APER_MAX;
        aperture = too_big ? '0 : ap_full[APER_W-1:0];
        wide     = lg > LOG_W'(WIDE_LOG2);
    end
endmodule

// File: rtl/bar_slot_map.sv
module bar_slot_map #(
    parameter int IDX_W    = 3,
    parameter int SLOTS    = 4,
    parameter int NUM_BARS = 6
) (
    input  logic [IDX_W-1:0]         idx,
    output logic                     word,
    output logic [$clog2(SLOTS)-1:0] slot,
    output logic                     idx_bad,
    output logic                     idx_odd
);
    localparam int SLOT_W = $clog2(SLOTS);

    always_comb begin
        word    = idx >= IDX_W'(SLOTS);
        slot    = idx[SLOT_W-1:0];
        idx_bad = idx >= IDX_W'(NUM_BARS);
        idx_odd = idx[0];
    end
endmodule

// File: rtl/bar_ctrl_select.sv
module bar_ctrl_select
    import bar_enc_pkg::*;
(
    input  logic      is_io,
    input  logic      prefetch,
    input  logic      wide,
    input  logic      off,
    output bar_ctrl_e ctrl
);
    always_comb begin
        if (off) begin
            ctrl = CTRL_OFF;
        end else if (is_io) begin
            ctrl = CTRL_IO32;
        end else begin
            unique case ({prefetch, wide})
                2'b11:   ctrl = CTRL_PMEM64;
                2'b10:   ctrl = CTRL_PMEM32;
                2'b01:   ctrl = CTRL_MEM64;
                default: ctrl = CTRL_MEM32;
            endcase
        end
    end
endmodule

// File: rtl/bar_cfg_encoder.sv
module bar_cfg_encoder
    import bar_enc_pkg::*;
#(
    parameter int SIZE_W    = 64,
    parameter int ADDR_W    = 64,
    parameter int APER_W    = 5,
    parameter int IDX_W     = 3,
    parameter int SLOTS     = 4,
    parameter int NUM_BARS  = 6,
    parameter int MIN_LOG2  = 7,
    parameter int WIDE_LOG2 = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [SIZE_W-1:0] in_size,
    input  logic              in_is_io,
    input  logic              in_prefetch,
    input  logic              in_mem64,
    input  logic              in_disable,
    input  logic [IDX_W-1:0]  in_bar,
    input  logic [ADDR_W-1:0] in_base,
    output logic              out_valid,
    output logic [APER_W-1:0] out_aperture,
    output logic [2:0]        out_ctrl,
    output logic              out_word,
    output logic [1:0]        out_slot,
    output logic              out_mem64,
    output logic              out_err,
    output logic [31:0]       out_addr_lo,
    output logic [31:0]       out_addr_hi
);
    localparam int HALF_W = ADDR_W / 2;
    localparam int SLOT_W = $clog2(SLOTS);

    typedef struct packed {
        logic              valid;
        logic              ready;
        logic [APER_W-1:0] aper;
        logic [CTRL_W-1:0] ctrl;
        logic              word;
        logic [SLOT_W-1:0] slot;
        logic              mem64;
        logic              err;
        logic [HALF_W-1:0] lo;
        logic [HALF_W-1:0] hi;
    } enc_state_t;

    enc_state_t state_d, state_q;

    logic [APER_W-1:0] aper_w;
    logic              wide_w, too_big_w;
    logic              word_w, idx_bad_w, idx_odd_w;
    logic [SLOT_W-1:0] slot_w;
    bar_ctrl_e         ctrl_w;

    bar_size_class #(
        .SIZE_W(SIZE_W), .APER_W(APER_W),
        .MIN_LOG2(MIN_LOG2), .WIDE_LOG2(WIDE_LOG2)
    ) u_size (
        .req_size(in_size), .aperture(aper_w), .wide(wide_w), .too_big(too_big_w)
    );

    bar_slot_map #(
        .IDX_W(IDX_W), .SLOTS(SLOTS), .NUM_BARS(NUM_BARS)
    ) u_slot (
        .idx(in_bar), .word(word_w), .slot(slot_w),
        .idx_bad(idx_bad_w), .idx_odd(idx_odd_w)
    );

    bar_ctrl_select u_ctrl (
        .is_io(in_is_io), .prefetch(in_prefetch), .wide(wide_w),
        .off(in_disable), .ctrl(ctrl_w)
    );

    always_comb begin
        logic accept, reject, wide_mem;
        state_d       = state_q;
        state_d.ready = 1'b1;
        accept        = in_valid && state_q.ready;
        state_d.valid = accept;
        wide_mem      = !in_is_io && wide_w;
        reject        = idx_bad_w ||
                        (!in_disable && (too_big_w || (wide_mem && idx_odd_w)));
        if (accept) begin
            state_d.word  = word_w;
            state_d.slot  = slot_w;
            state_d.err   = reject;
            state_d.mem64 = in_mem64 || (wide_mem && !reject && !in_disable);
            if (reject || in_disable) begin
                state_d.aper = '0;
                state_d.ctrl = CTRL_OFF;
                state_d.lo   = '0;
                state_d.hi   = '0;
            end else begin
                state_d.aper = aper_w;
                state_d.ctrl = ctrl_w;
                state_d.lo   = in_base[HALF_W-1:0];
                state_d.hi   = in_base[ADDR_W-1:HALF_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign in_ready     = state_q.ready;
    assign out_valid    = state_q.valid;
    assign out_aperture = state_q.aper;
    assign out_ctrl     = state_q.ctrl;
    assign out_word     = state_q.word;
    assign out_slot     = state_q.slot;
    assign out_mem64    = state_q.mem64;
    assign out_err      = state_q.err;
    assign out_addr_lo  = state_q.lo;
    assign out_addr_hi  = state_q.hi;

    // R12
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.valid && state_q.err) |-> (state_q.ctrl == CTRL_OFF && state_q.aper == '0));

    // R6
    wide_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.valid && (state_q.ctrl == CTRL_MEM64 || state_q.ctrl == CTRL_PMEM64))
        |-> !state_q.slot[0]);

    // R7
    wide_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.valid && (state_q.ctrl == CTRL_MEM64 || state_q.ctrl == CTRL_PMEM64))
        |-> state_q.mem64);

    // R11
    one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.valid |-> $past(in_valid && state_q.ready));
endmodule

// File: tb/bar_cfg_encoder_tb.sv
module bar_cfg_encoder_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_size = '0;
    logic        in_is_io = 1'b0, in_prefetch = 1'b0, in_mem64 = 1'b0, in_disable = 1'b0;
    logic [2:0]  in_bar = '0;
    logic [63:0] in_base = '0;
    logic        out_valid, out_word, out_mem64, out_err;
    logic [4:0]  out_aperture;
    logic [2:0]  out_ctrl;
    logic [1:0]  out_slot;
    logic [31:0] out_addr_lo, out_addr_hi;

    int tests = 0, fails = 0, cycles = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bar_cfg_encoder dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_size(in_size), .in_is_io(in_is_io), .in_prefetch(in_prefetch),
        .in_mem64(in_mem64), .in_disable(in_disable), .in_bar(in_bar),
        .in_base(in_base), .out_valid(out_valid), .out_aperture(out_aperture),
        .out_ctrl(out_ctrl), .out_word(out_word), .out_slot(out_slot),
        .out_mem64(out_mem64), .out_err(out_err), .out_addr_lo(out_addr_lo),
        .out_addr_hi(out_addr_hi)
    );

    // reference model state
    bit          e_ready = 0, e_valid = 0, e_word = 0, e_m64 = 0, e_err = 0;
    int          e_ap = 0, e_ctrl = 0, e_slot = 0;
    logic [31:0] e_lo = '0, e_hi = '0;
    string       e_tag = "R11";

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            e_valid = 0; e_ready = 0;
        end else begin
            e_valid = in_valid && e_ready;
            if (e_valid) begin
                int  lg;
                bit  wide, rej;
                lg = 7;
                while (lg < 64 && ((64'd1 << lg) < in_size)) lg++;
                wide   = !in_is_io && lg > 31;
                rej    = (in_bar > 5) ||
                         (!in_disable && ((lg - 7 > 31) || (wide && in_bar[0])));
                e_word = in_bar >= 4;
                e_slot = in_bar % 4;
                e_err  = rej;
                e_m64  = in_mem64 || (wide && !rej && !in_disable);
                if (rej || in_disable) begin
                    e_ap = 0; e_ctrl = 0; e_lo = 0; e_hi = 0;
                end else begin
                    e_ap = lg - 7;
                    if (in_is_io) e_ctrl = 1;
                    else e_ctrl = 4 + (in_prefetch ? 1 : 0) + (wide ? 2 : 0);
                    e_lo = in_base[31:0]; e_hi = in_base[63:32];
                end
                e_tag = in_disable ? "R10" : rej ? "R12/R3/R6" :
                        in_is_io ? "R4" : wide ? "R5/R7" : "R1/R2";
            end
            e_ready = 1;
        end
    end

    always @(negedge clk) begin
        if (!finished) begin
            chk(in_ready == e_ready, "R11 ready", in_ready, e_ready);
            chk(out_valid == e_valid, "R11 valid", out_valid, e_valid);
            if (e_valid) begin
                chk(out_aperture == e_ap, {e_tag, " R2 aperture"}, out_aperture, e_ap);
                chk(out_ctrl == e_ctrl, {e_tag, " R5 ctrl"}, out_ctrl, e_ctrl);
                chk(out_err == e_err, {e_tag, " R6 err"}, out_err, e_err);
                chk(out_mem64 == e_m64, {e_tag, " R7 mem64"}, out_mem64, e_m64);
                chk(out_word == e_word && out_slot == e_slot, "R8 slot",
                    {out_word, out_slot}, {e_word, 2'(e_slot)});
                chk(out_addr_lo == e_lo && out_addr_hi == e_hi, {e_tag, " R9 addr"},
                    {out_addr_hi, out_addr_lo}, {e_hi, e_lo});
            end
        end
    end

    task automatic send(input logic [63:0] sz, input bit io, input bit pf, input bit m64,
                        input bit dis, input int bar, input logic [63:0] base);
        @(negedge clk);
        in_valid = 1; in_size = sz; in_is_io = io; in_prefetch = pf;
        in_mem64 = m64; in_disable = dis; in_bar = 3'(bar); in_base = base;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 0;
        end
    endtask

    task automatic finish_run();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            tests++; fails++;
            $display("FAIL R11: watchdog expired, actual %0d expected %0d", cycles, 20000);
            finish_run();
        end
    end

    initial begin
        idle(3);
        // R11 reset state
        chk(out_valid == 0 && out_aperture == 0 && out_ctrl == 0, "R11 reset", out_valid, 0);
        @(negedge clk); rst_n = 1;
        idle(2);
        // R1 floor
        send(64'd0, 0, 0, 0, 0, 0, 64'h1234_5678_9abc_def0); idle(1);
        send(64'd1, 0, 0, 0, 0, 1, 64'h10); idle(1);
        send(64'd127, 0, 1, 0, 0, 2, 64'h20);
        send(64'd128, 0, 0, 0, 0, 3, 64'h30);
        // R2 rounding
        send(64'd129, 0, 0, 0, 0, 4, 64'hffff_0000_0000_1000);
        send(64'd256, 0, 1, 0, 0, 5, 64'h40);
        send(64'd257, 0, 0, 0, 0, 0, 64'h50);
        send(64'd512, 0, 0, 1, 0, 1, 64'h60); idle(2);
        send(64'd3000, 0, 1, 0, 0, 2, 64'h70);
        // R5 2 GiB boundary
        send(64'h8000_0000, 0, 0, 0, 0, 1, 64'h80);
        send(64'h8000_0001, 0, 0, 0, 0, 0, 64'h90);
        send(64'h8000_0001, 0, 1, 0, 0, 2, 64'ha0);
        send(64'h1_0000_0000, 0, 1, 1, 0, 4, 64'hb0);
        // R6 odd 64-bit
        send(64'h8000_0001, 0, 0, 0, 0, 1, 64'hc0);
        send(64'h2_0000_0000, 0, 1, 0, 0, 5, 64'hd0);
        // R3 code-width limit
        send(64'h40_0000_0000, 0, 0, 0, 0, 0, 64'he0);
        send(64'h40_0000_0001, 0, 0, 0, 0, 0, 64'hf0);
        send(64'h8000_0000_0000_0005, 0, 0, 0, 0, 2, 64'h100);
        send(64'hffff_ffff_ffff_ffff, 1, 0, 0, 0, 0, 64'h110);
        // R4 io
        send(64'h1_0000_0000, 1, 1, 0, 0, 3, 64'h120);
        send(64'd16, 1, 0, 1, 0, 5, 64'h130);
        // R10 disable
        send(64'hffff_ffff_ffff_ffff, 0, 1, 1, 1, 1, 64'hdead_beef_dead_beef);
        send(64'd4096, 1, 0, 0, 1, 4, 64'h140);
        // R12 bad index
        send(64'd256, 0, 0, 1, 0, 6, 64'h150);
        send(64'd256, 0, 0, 0, 1, 7, 64'h160);
        idle(3);
        finish_run();
    end
endmodule